// File: doc/BRIEF.md
# Write-Protected Two-Level Pin Function Configuration

This block holds the per-pin configuration of a pin multiplexer with up to 170 pins, split into two banks. The first-level bank keeps a 4-bit function code, a pull setting and a drive-strength code for each pin. The second-level bank keeps an extended 6-bit function number per pin and two source selectors for the two management-data (MDIO) channels. From the two banks the block computes, for every pin, one effective function number. It also flags the pins that are left floating. The pull and drive codes go straight out to the pad ring.

Each bank has its own write guard. A bank leaves reset locked, and while it is locked every write to its configuration words and source selectors is dropped. To change the lock state, software writes a key to the bank's protect register at word offset 0x400. The key is that register's own full bus address: bit 0 clear locks the bank, and bit 0 set unlocks it. The bus is a plain register port with no back-pressure. A write completes in the cycle it is presented. Read data appears on the cycle after the address. Bus address bit 12 selects the bank (0 for the first level, 1 for the second). Bits 11:2 give the word index, and bits 1:0 are ignored.

Top module: `pinmux_cfg_bank`

## Requirements
- R1: After reset both banks are locked and all stored fields are zero. A protect-register read returns 1 in bit 0, every pin reports function 0, pull 0, drive 0 and not floating, and both source selectors read 0.
- R2: The key for the first-level bank is BASE_ADDR+0x400 and the key for the second-level bank is BASE_ADDR+0x1400. Writing a bank's key to its protect register locks that bank. Writing the key with bit 0 set unlocks it. Any other written value leaves the lock state unchanged. Bits 31:1 of a protect read are zero.
- R3: While a bank is locked, writes to its configuration words and source selectors leave the stored values, and the outputs derived from them, unchanged.
- R4: A first-level word keeps the function code in bits 3:0, the pull code in bits 9:8 and the drive code in bits 11:10. All its other bits read as zero.
- R5: A first-level code from 0 to 9 makes that code the pin's effective function.
- R6: A first-level code of 15 makes the effective function 10 plus the second-level value. The second-level value is stored in bits 5:0 of the second-level word, and its other bits read as zero.
- R7: Codes 10 to 14, and code 15 with a second-level value above 61, give the effective function 127, meaning no valid function.
- R8: A pin is reported floating exactly when its first-level code is 15 and its second-level value is 0.
- R9: The pull output (0 none, 1 up, 3 down) and the drive output (0 to 3 for 4, 6, 8 and 12 mA) present the stored codes whatever the function.
- R10: The second-level bank keeps source selectors for channels 0 and 1 at offsets 0x404 and 0x408, each 3 bits wide, where source 0 means high impedance. At the same offsets the first-level bank reads zero.
- R11: Reserved offsets read as zero and ignore writes. These are the words from NUM_PINS up to 255, and the unmapped words above the protect register.
- R12: The two banks lock and unlock independently. A key meant for one bank has no effect on the other.
- R13: Read data for an address is valid on the cycle after the address is presented, so reads can be issued back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 13 | Byte address; bit 12 picks the bank |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| pin_func | output | NUM_PINS*7 | Effective function per pin, 127 if none |
| pin_pull | output | NUM_PINS*2 | Pull code per pin |
| pin_drive | output | NUM_PINS*2 | Drive-strength code per pin |
| pin_hiz | output | NUM_PINS | Pin left floating |
| mdio_src | output | 6 | Channel 1 source in bits 5:3, channel 0 in bits 2:0 |

## Verification
The hardest state to reach is a pin's extended function taking effect. Both banks have to be unlocked by their own keys, and the first-level code has to hand the pin over with 15, before any second-level value reaches the output. On top of that, the 61/62 boundary only shows once both of those conditions hold. The stimulus first tries the wrong bank's key and a stray value, and checks that nothing moves. It then opens the banks one at a time, so every dropped write and every key mix-up can be seen at the outputs. A scoreboard queue holds the expected read data in issue order, so back-to-back reads test the one-cycle read latency directly.

// File: rtl/pmx_cfg_pkg.sv
package pmx_cfg_pkg;
  localparam int WORD_W    = 32;
  localparam int IDX_W     = 10;
  localparam int BUS_ADDR_W = IDX_W + 3;
  localparam int BANK_BIT  = IDX_W + 2;
  localparam int CODE_W    = 4;
  localparam int PULL_W    = 2;
  localparam int DRV_W     = 2;
  localparam int L1_CFG_W  = CODE_W + PULL_W + DRV_W;
  localparam int L2_CFG_W  = 6;
  localparam int MDIO_W    = 3;
  localparam int MDIO_CH   = 2;
  localparam int EFF_W     = 7;
  localparam int PULL_LSB  = 8;
  localparam int DRV_LSB   = 10;

  localparam logic [CODE_W-1:0]   CODE_DEFER      = 4'hF;
  localparam logic [CODE_W-1:0]   CODE_DIRECT_MAX = 4'd9;
  localparam logic [L2_CFG_W-1:0] L2_MAX          = 6'd61;
  localparam logic [EFF_W-1:0]    EFF_L2_BASE     = 7'd10;
  localparam logic [EFF_W-1:0]    EFF_NONE        = 7'd127;

  localparam logic [IDX_W-1:0] IDX_PROT  = 10'h100;
  localparam logic [IDX_W-1:0] IDX_MDIO0 = 10'h101;
  localparam logic [IDX_W-1:0] IDX_MDIO1 = 10'h102;
  localparam logic [31:0]      PROT_OFFSET = 32'h0000_0400;
  localparam logic [31:0]      BANK2_OFFSET = 32'h0000_1000;

  typedef enum logic [1:0] {RG_CFG, RG_PROT, RG_MDIO, RG_RSVD} region_e;
endpackage

// File: rtl/pmx_lock_ctrl.sv
module pmx_lock_ctrl #(
  parameter logic [31:0] KEY = 32'h0000_0400
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic        locked
);
  localparam logic [31:0] UNLOCK_KEY = KEY | 32'h1;

  always_ff @(posedge clk) begin
    if (!rst_n)                             locked <= 1'b1;
    else if (wr && wdata == KEY)            locked <= 1'b1;
    else if (wr && wdata == UNLOCK_KEY)     locked <= 1'b0;
  end

  // R2
  stray_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked && !(wr && wdata == UNLOCK_KEY) |=> locked);
  // R2
  unlock_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(wr) && $past(wdata) == UNLOCK_KEY);
  // R2
  lock_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(wr) && $past(wdata) == KEY);
endmodule

// File: rtl/pmx_word_store.sv
module pmx_word_store #(
  parameter int NUM_PINS = 170,
  parameter int W        = 8,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [PIN_W-1:0]      pin,
  input  logic [W-1:0]          wr_val,
  output logic [W-1:0]          rd_val,
  output logic [NUM_PINS*W-1:0] cfg_flat
);
  logic [NUM_PINS*W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q[int'(pin)*W +: W] <= wr_val;
  end

  always_comb begin
    rd_val = '0;
    if (int'(pin) < NUM_PINS) rd_val = cfg_q[int'(pin)*W +: W];
  end

  assign cfg_flat = cfg_q;
endmodule

// File: rtl/pmx_level_bank.sv
module pmx_level_bank import pmx_cfg_pkg::*; #(
  parameter int          LEVEL     = 1,
  parameter int          NUM_PINS  = 170,
  parameter int          CFG_W     = L1_CFG_W,
  parameter logic [31:0] PROT_ADDR = 32'h0000_0400,
  localparam int         PIN_W     = $clog2(NUM_PINS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel,
  input  logic [IDX_W-1:0]          idx,
  input  logic                      we,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output logic [NUM_PINS*CFG_W-1:0] cfg_flat,
  output logic [MDIO_CH*MDIO_W-1:0] mdio_flat,
  output logic                      locked
);
  localparam logic [IDX_W-1:0] NPIN_IDX = IDX_W'(NUM_PINS);

  region_e           region;
  logic              wr_prot, wr_cfg, wr_mdio;
  logic [CFG_W-1:0]  wr_val, rd_val;
  logic [31:0]       cfg_rd;

  always_comb begin
    region = RG_RSVD;
    if (idx < NPIN_IDX)                                  region = RG_CFG;
    else if (idx == IDX_PROT)                            region = RG_PROT;
    else if (LEVEL == 2 && (idx == IDX_MDIO0 || idx == IDX_MDIO1)) region = RG_MDIO;
  end

  assign wr_prot = we && sel && region == RG_PROT;
  assign wr_cfg  = we && sel && region == RG_CFG  && !locked;
  assign wr_mdio = we && sel && region == RG_MDIO && !locked;

  pmx_lock_ctrl #(.KEY(PROT_ADDR)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr(wr_prot), .wdata(wdata), .locked(locked)
  );

  pmx_word_store #(.NUM_PINS(NUM_PINS), .W(CFG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_cfg), .pin(idx[PIN_W-1:0]),
    .wr_val(wr_val), .rd_val(rd_val), .cfg_flat(cfg_flat)
  );

  generate
    if (LEVEL == 1) begin : g_l1_fmt
      // stored as {drive, pull, code}
      assign wr_val = {wdata[DRV_LSB +: DRV_W], wdata[PULL_LSB +: PULL_W], wdata[CODE_W-1:0]};
      assign cfg_rd = {20'b0, rd_val[7:6], rd_val[5:4], 4'b0, rd_val[3:0]};
      assign mdio_flat = '0;
    end else begin : g_l2_fmt
      logic [MDIO_W-1:0] mdio_q [MDIO_CH];
      assign wr_val = wdata[CFG_W-1:0];
      assign cfg_rd = {{(32-CFG_W){1'b0}}, rd_val};
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int c = 0; c < MDIO_CH; c++) mdio_q[c] <= '0;
        end else if (wr_mdio) begin
          mdio_q[idx[0] ? 0 : 1] <= wdata[MDIO_W-1:0];
        end
      end
      for (genvar c = 0; c < MDIO_CH; c++) begin : g_mdio_out
        assign mdio_flat[c*MDIO_W +: MDIO_W] = mdio_q[c];
      end
    end
  endgenerate

  always_comb begin
    unique case (region)
      RG_CFG:  rdata = cfg_rd;
      RG_PROT: rdata = {31'b0, locked};
      RG_MDIO: rdata = {29'b0, mdio_flat[(idx[0] ? 0 : 1)*MDIO_W +: MDIO_W]};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pmx_pin_decode.sv
module pmx_pin_decode import pmx_cfg_pkg::*; #(
  parameter int NUM_PINS = 170
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PINS*L1_CFG_W-1:0] l1_flat,
  input  logic [NUM_PINS*L2_CFG_W-1:0] l2_flat,
  output logic [NUM_PINS*EFF_W-1:0]    pin_func,
  output logic [NUM_PINS*PULL_W-1:0]   pin_pull,
  output logic [NUM_PINS*DRV_W-1:0]    pin_drive,
  output logic [NUM_PINS-1:0]          pin_hiz
);
  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic [CODE_W-1:0]   code;
      logic [L2_CFG_W-1:0] ext;
      logic [EFF_W-1:0]    eff;

      assign code = l1_flat[i*L1_CFG_W +: CODE_W];
      assign ext  = l2_flat[i*L2_CFG_W +: L2_CFG_W];

      always_comb begin
        if (code <= CODE_DIRECT_MAX)                 eff = EFF_W'(code);
        else if (code == CODE_DEFER && ext <= L2_MAX) eff = EFF_L2_BASE + EFF_W'(ext);
        else                                          eff = EFF_NONE;
      end

      assign pin_func[i*EFF_W +: EFF_W]    = eff;
      assign pin_pull[i*PULL_W +: PULL_W]  = l1_flat[i*L1_CFG_W + CODE_W +: PULL_W];
      assign pin_drive[i*DRV_W +: DRV_W]   = l1_flat[i*L1_CFG_W + CODE_W + PULL_W +: DRV_W];
      assign pin_hiz[i] = (code == CODE_DEFER) && (ext == '0);

      // R8
      hiz_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_hiz[i] |-> pin_func[i*EFF_W +: EFF_W] == EFF_L2_BASE);
      // R7
      func_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_func[i*EFF_W +: EFF_W] <= 7'd71 || pin_func[i*EFF_W +: EFF_W] == EFF_NONE);
    end
  endgenerate
endmodule

// File: rtl/pinmux_cfg_bank.sv
module pinmux_cfg_bank import pmx_cfg_pkg::*; #(
  parameter int          NUM_PINS  = 170,
  parameter logic [31:0] BASE_ADDR = 32'h4006_7000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [BUS_ADDR_W-1:0]        bus_addr,
  input  logic                         bus_we,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  output logic [NUM_PINS*EFF_W-1:0]    pin_func,
  output logic [NUM_PINS*PULL_W-1:0]   pin_pull,
  output logic [NUM_PINS*DRV_W-1:0]    pin_drive,
  output logic [NUM_PINS-1:0]          pin_hiz,
  output logic [MDIO_CH*MDIO_W-1:0]    mdio_src
);
  localparam logic [31:0] L1_PROT = BASE_ADDR + PROT_OFFSET;
  localparam logic [31:0] L2_PROT = BASE_ADDR + BANK2_OFFSET + PROT_OFFSET;
  localparam logic [IDX_W-1:0] NPIN_IDX = IDX_W'(NUM_PINS);

  logic [IDX_W-1:0]               idx;
  logic                           bank2;
  logic [1:0]                     unused_byte_lane;
  logic [31:0]                    l1_rd, l2_rd;
  logic [NUM_PINS*L1_CFG_W-1:0]   l1_cfg;
  logic [NUM_PINS*L2_CFG_W-1:0]   l2_cfg;
  logic [MDIO_CH*MDIO_W-1:0]      l1_mdio, l2_mdio;
  logic                           l1_locked, l2_locked;

  assign idx   = bus_addr[IDX_W+1:2];
  assign bank2 = bus_addr[BANK_BIT];
  assign unused_byte_lane = bus_addr[1:0];

  pmx_level_bank #(.LEVEL(1), .NUM_PINS(NUM_PINS), .CFG_W(L1_CFG_W), .PROT_ADDR(L1_PROT)) u_l1 (
    .clk(clk), .rst_n(rst_n), .sel(!bank2), .idx(idx), .we(bus_we), .wdata(bus_wdata),
    .rdata(l1_rd), .cfg_flat(l1_cfg), .mdio_flat(l1_mdio), .locked(l1_locked)
  );

  pmx_level_bank #(.LEVEL(2), .NUM_PINS(NUM_PINS), .CFG_W(L2_CFG_W), .PROT_ADDR(L2_PROT)) u_l2 (
    .clk(clk), .rst_n(rst_n), .sel(bank2), .idx(idx), .we(bus_we), .wdata(bus_wdata),
    .rdata(l2_rd), .cfg_flat(l2_cfg), .mdio_flat(l2_mdio), .locked(l2_locked)
  );

  pmx_pin_decode #(.NUM_PINS(NUM_PINS)) u_dec (
    .clk(clk), .rst_n(rst_n), .l1_flat(l1_cfg), .l2_flat(l2_cfg),
    .pin_func(pin_func), .pin_pull(pin_pull), .pin_drive(pin_drive), .pin_hiz(pin_hiz)
  );

  // first-level bank has no source selectors; its port is tied to zero
  assign mdio_src = l2_mdio | l1_mdio;

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bank2 ? l2_rd : l1_rd;
  end

  logic rsvd_rd;
  assign rsvd_rd = idx >= NPIN_IDX && idx != IDX_PROT &&
                   !(bank2 && (idx == IDX_MDIO0 || idx == IDX_MDIO1));

  // R3
  l1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_locked |=> $stable(l1_cfg));
  // R3
  l2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l2_locked |=> $stable(l2_cfg) && $stable(mdio_src));
  // R11
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rsvd_rd) |-> bus_rdata == 32'h0);
  // R12
  bank_indep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_we) && !$past(bank2) |-> l2_locked == $past(l2_locked));
endmodule

// File: tb/sim_pinmux_cfg_bank.sv
`timescale 1ns/1ps
module sim_pinmux_cfg_bank;
  localparam int          NP   = 170;
  localparam logic [31:0] BASE = 32'h4006_7000;
  localparam logic [31:0] K1   = BASE + 32'h400;
  localparam logic [31:0] K2   = BASE + 32'h1400;

  logic             clk, rst_n, bus_we;
  logic [12:0]      bus_addr;
  logic [31:0]      bus_wdata, bus_rdata;
  logic [NP*7-1:0]  pin_func;
  logic [NP*2-1:0]  pin_pull, pin_drive;
  logic [NP-1:0]    pin_hiz;
  logic [5:0]       mdio_src;

  pinmux_cfg_bank #(.NUM_PINS(NP), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_func(pin_func),
    .pin_pull(pin_pull), .pin_drive(pin_drive), .pin_hiz(pin_hiz), .mdio_src(mdio_src)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic rd_req = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data one cycle after each read address
  always @(posedge clk) begin
    if (rd_req) begin
      logic [31:0] e;
      string t;
      #1;
      if (exp_q.size() == 0) begin
        check("R13 unexpected read", 32'h1, 32'h0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  task automatic wr(logic [12:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d; rd_req = 1'b0;
  endtask

  task automatic rd(logic [12:0] a, logic [31:0] e, string tag);
    @(negedge clk); bus_addr = a; bus_we = 1'b0; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk); bus_we = 1'b0; rd_req = 1'b0;
  endtask

  function automatic logic [31:0] fn(int p); return 32'(pin_func[p*7 +: 7]); endfunction
  function automatic logic [31:0] pl(int p); return 32'(pin_pull[p*2 +: 2]); endfunction
  function automatic logic [31:0] dr(int p); return 32'(pin_drive[p*2 +: 2]); endfunction

  // requirement model of the effective function (R5, R6, R7)
  function automatic logic [31:0] model_func(int code, int ext);
    if (code <= 9) return 32'(code);
    if (code == 15 && ext <= 61) return 32'(10 + ext);
    return 32'd127;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(13'h0400, 32'h1, "R1 l1 locked at reset");
    rd(13'h1400, 32'h1, "R1 l2 locked at reset");
    rd(13'h0000, 32'h0, "R1 pin0 zero");
    rd(13'h02A4, 32'h0, "R1 pin169 zero");
    rd(13'h1404, 32'h0, "R1 mdio0 zero");
    idle();
    check("R1 func pin5", fn(5), 32'h0);
    check("R1 no hiz", 32'(pin_hiz == '0), 32'h1);
    check("R1 mdio outputs", 32'(mdio_src), 32'h0);

    // R3 locked write dropped
    wr(13'h000C, 32'h0000_000F);
    rd(13'h000C, 32'h0, "R3 locked l1 write dropped");
    idle();
    check("R3 func pin3 unchanged", fn(3), 32'h0);

    // R2 / R12 stray and wrong-bank keys
    wr(13'h0400, 32'h1234_5678);
    rd(13'h0400, 32'h1, "R2 stray value keeps lock");
    wr(13'h0400, K2 | 32'h1);
    rd(13'h0400, 32'h1, "R12 other bank key ignored");
    wr(13'h0400, K1 | 32'h1);
    rd(13'h0400, 32'h0, "R2 l1 unlocked by key");
    rd(13'h1400, 32'h1, "R12 l2 still locked");

    // R4 / R6 / R8 field layout and hand-over
    wr(13'h000C, 32'hFFFF_FFFF);
    rd(13'h000C, 32'h0000_0F0F, "R4 l1 field layout");
    wr(13'h100C, 32'h0000_0005);
    rd(13'h100C, 32'h0, "R3 locked l2 write dropped");
    idle();
    check("R8 hiz on defer with ext 0", 32'(pin_hiz[3]), 32'h1);
    check("R6 func defer ext 0", fn(3), model_func(15, 0));
    check("R9 pull pin3", pl(3), 32'h3);
    check("R9 drive pin3", dr(3), 32'h3);

    wr(13'h1400, K2 | 32'h1);
    rd(13'h1400, 32'h0, "R2 l2 unlocked by key");
    wr(13'h100C, 32'hFFFF_FFC5);
    rd(13'h100C, 32'h5, "R6 l2 field bits 5:0 only");
    idle();
    check("R6 func 10+5", fn(3), model_func(15, 5));
    check("R8 hiz clear when ext nonzero", 32'(pin_hiz[3]), 32'h0);
    wr(13'h100C, 32'd61);
    idle();
    check("R6 func upper bound 71", fn(3), model_func(15, 61));
    wr(13'h100C, 32'd62);
    idle();
    check("R7 ext 62 gives none", fn(3), model_func(15, 62));

    // R5 / R7 / R9 direct codes
    wr(13'h0000, 32'h0000_0009);
    wr(13'h02A4, 32'h0000_0B07);
    wr(13'h001C, 32'h0000_000C);
    idle();
    check("R5 direct code 9", fn(0), model_func(9, 0));
    check("R5 direct code 7 last pin", fn(169), model_func(7, 0));
    check("R9 pull pin169", pl(169), 32'h3);
    check("R9 drive pin169", dr(169), 32'h2);
    check("R7 code 12 gives none", fn(7), model_func(12, 0));
    check("R8 no hiz on direct code", 32'(pin_hiz[0]), 32'h0);

    // R10 source selectors
    wr(13'h1404, 32'h0000_0006);
    wr(13'h1408, 32'h0000_000F);
    wr(13'h0404, 32'h0000_0005);
    rd(13'h1404, 32'h6, "R10 mdio0 readback");
    rd(13'h1408, 32'h7, "R10 mdio1 three bits");
    rd(13'h0404, 32'h0, "R10 l1 has no mdio");
    idle();
    check("R10 mdio outputs", 32'(mdio_src), 32'h3E);

    // R11 reserved offsets
    wr(13'h02A8, 32'hFFFF_FFFF);
    wr(13'h03FC, 32'hFFFF_FFFF);
    wr(13'h140C, 32'hFFFF_FFFF);
    rd(13'h02A8, 32'h0, "R11 word 170 reads zero");
    rd(13'h03FC, 32'h0, "R11 word 255 reads zero");
    rd(13'h140C, 32'h0, "R11 l2 word above mdio zero");
    idle();
    check("R11 pin169 untouched", fn(169), 32'd7);

    // R3 relock and drop
    wr(13'h1400, K2);
    wr(13'h1404, 32'h0000_0001);
    rd(13'h1400, 32'h1, "R2 l2 relocked");
    rd(13'h1404, 32'h6, "R3 locked mdio write dropped");
    wr(13'h0400, K1);
    wr(13'h0000, 32'h0000_0003);
    idle();
    check("R3 pin0 func held", fn(0), 32'd9);
    check("R3 mdio output held", 32'(mdio_src), 32'h3E);

    // R13 back-to-back reads
    rd(13'h0000, 32'h9, "R13 b2b pin0");
    rd(13'h02A4, 32'hB07, "R13 b2b pin169");
    rd(13'h0400, 32'h1, "R13 b2b protect");
    idle();
    idle();
    check("R13 scoreboard drained", 32'(exp_q.size()), 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule